// File: doc/BRIEF.md
# GPIO controller with edge interrupts

A memory-mapped general-purpose I/O block with up to two register sets of 32 pins each. Software reaches it over a simple 32-bit register bus: an address, a write strobe and write data, with read data returned in the same cycle as the address. Each pin has a direction bit and an output level. The output level changes only through write-one-to-set and write-one-to-clear aliases. The level on the pin is synchronized and can always be read back, whatever the pin's direction.

Each pin can raise an interrupt on a rising edge, a falling edge, or both. The rising and falling enables are separate per-pin masks, and each changes only through its own set and clear aliases. An enabled edge latches a sticky status bit, and software clears that bit by writing a one to it. The status bits are grouped into 16-pin banks. Each bank drives its own interrupt line, and a global per-bank enable register gates every line.

Top module: `gpioe_ctrl`

## Requirements
- R1: After reset every pin is an input (direction all ones), every output bit is 0, every edge enable and status bit is 0, the bank enable register is 0 and every interrupt line is low.
- R2: Register set k starts at byte address 0x10 + 0x28*k. Its direction word at offset 0x00 is written and read as a whole. A 1 bit makes the pin an input and a 0 bit makes it an output, and `pin_dir` shows the register.
- R3: Writing a mask to offset 0x08 drives the masked output bits high, and writing a mask to offset 0x0C drives them low. Bits written as 0 keep their value. `pin_out` shows the output register in the cycle after the write, and reading either alias returns the output register.
- R4: Offset 0x04 reads the output register. A write to it has no effect.
- R5: Offset 0x10 returns the pin level after a two-flop synchronizer, so a change on `pin_in` can be read after two clock edges. The readback works for output pins too, and a write to this offset has no effect.
- R6: Offsets 0x14 and 0x18 set and clear bits of the rising-edge enable mask, and offsets 0x1C and 0x20 set and clear bits of the falling-edge enable mask. Reading any of these four offsets returns the mask it controls.
- R7: A status bit (offset 0x24) is latched when the synchronized pin level differs from its value one clock earlier in an enabled direction. For a change on `pin_in` ahead of clock edge 1, the bit is set at edge 3.
- R8: Writing 1 to a status bit clears it, and bits written as 0 keep their value. If a new enabled edge arrives in the same cycle as the clear, the bit stays set.
- R9: The bank enable register is at 0x08, with bit b belonging to bank b. Status bits 15:0 of set k form bank 2k and bits 31:16 form bank 2k+1. `bank_irq[b]` is high exactly when bank b has a status bit set and its enable bit is 1.
- R10: A read of an address that maps to no register returns 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_in | input | 64 | Asynchronous pin levels |
| pin_out | output | 64 | Output levels |
| pin_dir | output | 64 | Per-pin direction, 1 = input |
| bank_irq | output | 4 | One interrupt line per 16-pin bank |

## Verification
Two things can happen to a status bit in the same clock: software clears it with a write-one, and a new enabled edge reaches the edge detector. The bench times a pin change so that its edge lands on the third clock edge, which is the edge at which it issues the clear. It then checks that the bit still reads 1 and that the bank line stays high. Random traffic over the whole address map, mixed with sparse pin toggles, lets alias writes, clears and edges coincide many more times, and a bench model computed from the requirements judges every cycle.

// File: rtl/gpioe_pkg.sv
package gpioe_pkg;

    localparam int unsigned ADDR_W       = 8;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned SET_W        = 32;
    localparam int unsigned HALF_W       = 16;
    localparam int unsigned SYNC_STAGES  = 2;
    localparam int unsigned SET_BASE_I   = 'h10;
    localparam int unsigned SET_STRIDE_I = 'h28;
    localparam int unsigned LAST_OFF_I   = 'h24;
    localparam logic [ADDR_W-1:0] BANK_EN_ADDR = 8'h08;

    typedef enum logic [3:0] {
        REG_DIR  = 4'd0,
        REG_OUT  = 4'd1,
        REG_OSET = 4'd2,
        REG_OCLR = 4'd3,
        REG_IN   = 4'd4,
        REG_RSET = 4'd5,
        REG_RCLR = 4'd6,
        REG_FSET = 4'd7,
        REG_FCLR = 4'd8,
        REG_STAT = 4'd9,
        REG_NONE = 4'hF
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [WORD_W-1:0] data;
    } set_access_t;

    function automatic logic [ADDR_W-1:0] set_base(input int unsigned k);
        return ADDR_W'(SET_BASE_I + k * SET_STRIDE_I);
    endfunction

    function automatic reg_sel_e map_offset(input logic [ADDR_W-1:0] addr,
                                            input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] rel;
        rel = addr - base;
        if (addr < base || rel > ADDR_W'(LAST_OFF_I) || rel[1:0] != 2'b00)
            return REG_NONE;
        return reg_sel_e'(rel[5:2]);
    endfunction

endpackage

// File: rtl/gpioe_sync.sv
module gpioe_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[s] <= '0;
            else if (s == 0)
                stg[s] <= async_in;
            else
                stg[s] <= stg[(s == 0) ? 0 : s - 1];
        end
    end

    assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpioe_decode.sv
module gpioe_decode import gpioe_pkg::*; #(
    parameter int unsigned NUM_SETS = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output set_access_t       acc [NUM_SETS],
    output logic              en_hit
);

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam logic [ADDR_W-1:0] BASE = set_base(k);
        always_comb begin
            acc[k].sel  = map_offset(bus_addr, BASE);
            acc[k].we   = bus_we && (acc[k].sel != REG_NONE);
            acc[k].data = bus_wdata;
        end
    end

    assign en_hit = (bus_addr == BANK_EN_ADDR);

endmodule

// File: rtl/gpioe_regset.sv
module gpioe_regset import gpioe_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  set_access_t      acc,
    input  logic [SET_W-1:0] pin_sync,
    output logic [SET_W-1:0] dir_o,
    output logic [SET_W-1:0] out_o,
    output logic [SET_W-1:0] status_o,
    output logic [SET_W-1:0] rd_data
);

    logic [SET_W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
    logic [SET_W-1:0] hit_rise, hit_fall, clr_mask, stat_d;

    always_comb begin
        hit_rise = pin_sync & ~prev_q & rise_q;
        hit_fall = ~pin_sync & prev_q & fall_q;
        clr_mask = (acc.we && acc.sel == REG_STAT) ? acc.data : '0;
        stat_d   = (stat_q & ~clr_mask) | hit_rise | hit_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pin_sync;
            stat_q <= stat_d;
            if (acc.we) begin
                case (acc.sel)
                    REG_DIR:  dir_q  <= acc.data;
                    REG_OSET: out_q  <= out_q | acc.data;
                    REG_OCLR: out_q  <= out_q & ~acc.data;
                    REG_RSET: rise_q <= rise_q | acc.data;
                    REG_RCLR: rise_q <= rise_q & ~acc.data;
                    REG_FSET: fall_q <= fall_q | acc.data;
                    REG_FCLR: fall_q <= fall_q & ~acc.data;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (acc.sel)
            REG_DIR:                    rd_data = dir_q;
            REG_OUT, REG_OSET, REG_OCLR: rd_data = out_q;
            REG_IN:                     rd_data = pin_sync;
            REG_RSET, REG_RCLR:         rd_data = rise_q;
            REG_FSET, REG_FCLR:         rd_data = fall_q;
            REG_STAT:                   rd_data = stat_q;
            default:                    rd_data = '0;
        endcase
    end

    assign dir_o    = dir_q;
    assign out_o    = out_q;
    assign status_o = stat_q;

endmodule

// File: rtl/gpioe_irq.sv
module gpioe_irq import gpioe_pkg::*; #(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic [NUM_BANKS*HALF_W-1:0] status,
    input  logic [NUM_BANKS-1:0]        bank_en,
    output logic [NUM_BANKS-1:0]        irq
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign irq[b] = bank_en[b] & (|status[b*HALF_W +: HALF_W]);
    end

endmodule

// File: rtl/gpioe_ctrl.sv
module gpioe_ctrl import gpioe_pkg::*; #(
    parameter int unsigned NUM_SETS  = 2,
    localparam int unsigned NPINS    = NUM_SETS * SET_W,
    localparam int unsigned NBANKS   = NUM_SETS * (SET_W / HALF_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_dir,
    output logic [NBANKS-1:0] bank_irq
);

    set_access_t       acc [NUM_SETS];
    logic              en_hit;
    logic [NPINS-1:0]  pin_sync;
    logic [NPINS-1:0]  status_all;
    logic [SET_W-1:0]  set_rd [NUM_SETS];
    logic [NBANKS-1:0] bank_en_q;

    gpioe_decode #(.NUM_SETS(NUM_SETS)) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .acc      (acc),
        .en_hit   (en_hit)
    );

    gpioe_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(pin_in),
        .sync_out(pin_sync)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_regset
        gpioe_regset u_regset (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc[k]),
            .pin_sync(pin_sync[k*SET_W +: SET_W]),
            .dir_o   (pin_dir[k*SET_W +: SET_W]),
            .out_o   (pin_out[k*SET_W +: SET_W]),
            .status_o(status_all[k*SET_W +: SET_W]),
            .rd_data (set_rd[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            bank_en_q <= '0;
        else if (bus_we && en_hit)
            bank_en_q <= bus_wdata[NBANKS-1:0];
    end

    gpioe_irq #(.NUM_BANKS(NBANKS)) u_irq (
        .status (status_all),
        .bank_en(bank_en_q),
        .irq    (bank_irq)
    );

    always_comb begin
        bus_rdata = en_hit ? WORD_W'(bank_en_q) : '0;
        for (int k = 0; k < NUM_SETS; k++)
            bus_rdata = bus_rdata | set_rd[k];
    end

endmodule

// File: rtl/gpioe_ctrl_chk.sv
module gpioe_ctrl_chk import gpioe_pkg::*; #(
    parameter int unsigned NUM_SETS = 2,
    localparam int unsigned NPINS   = NUM_SETS * SET_W,
    localparam int unsigned NBANKS  = NUM_SETS * (SET_W / HALF_W)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_dir,
    input logic [NBANKS-1:0] bank_irq,
    input logic [NBANKS-1:0] bank_en
);

    localparam logic [ADDR_W-1:0] DIR0 = set_base(0);
    localparam logic [ADDR_W-1:0] OUT0 = set_base(0) + 8'h04;
    localparam logic [ADDR_W-1:0] SET0 = set_base(0) + 8'h08;
    localparam logic [ADDR_W-1:0] CLR0 = set_base(0) + 8'h0C;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_dir == '1 && pin_out == '0 && bank_irq == '0)); // R1

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == DIR0) |=> (pin_dir[SET_W-1:0] == $past(bus_wdata))); // R2

    AST_OUT_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SET0) |=> ((pin_out[SET_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_OUT_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CLR0) |=> ((pin_out[SET_W-1:0] & $past(bus_wdata)) == '0)); // R3

    AST_OUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OUT0) |=> $stable(pin_out)); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        ((bank_irq & ~bank_en) == '0)); // R9

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == BANK_EN_ADDR) |=> (bank_en == $past(bus_wdata[NBANKS-1:0]))); // R9

endmodule

bind gpioe_ctrl gpioe_ctrl_chk #(.NUM_SETS(NUM_SETS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_dir  (pin_dir),
    .bank_irq (bank_irq),
    .bank_en  (bank_en_q)
);

// File: tb/gpioe_ctrl_bench.sv
module gpioe_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 2;
    localparam int NP = 64;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_dir;
    logic [NB-1:0] bank_irq;

    int vectors = 0;
    int errors  = 0;

    // bench model of the register state
    logic [NP-1:0] m_dir, m_out, m_rise, m_fall, m_stat, m_s1, m_s2, m_prev;
    logic [NB-1:0] m_en;

    gpioe_ctrl u_gpioe_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .bank_irq(bank_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int set_of(input logic [7:0] a);
        for (int k = 0; k < NSETS; k++) begin
            int b;
            b = 'h10 + 'h28 * k;
            if (int'(a) >= b && int'(a) - b <= 'h24 && a[1:0] == 2'b00) return k;
        end
        return -1;
    endfunction

    function automatic int off_of(input logic [7:0] a, input int k);
        return (int'(a) - ('h10 + 'h28 * k)) / 4;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int k;
        k = set_of(a);
        if (a == 8'h08) return 32'(m_en);
        if (k < 0) return '0;
        case (off_of(a, k))
            0:       return m_dir[k*32 +: 32];
            1, 2, 3: return m_out[k*32 +: 32];
            4:       return m_s2[k*32 +: 32];
            5, 6:    return m_rise[k*32 +: 32];
            7, 8:    return m_fall[k*32 +: 32];
            default: return m_stat[k*32 +: 32];
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        int k;
        k = set_of(a);
        if (a == 8'h08) return "R9";
        if (k < 0) return "R10";
        case (off_of(a, k))
            0:       return "R2";
            1:       return "R4";
            2, 3:    return "R3";
            4:       return "R5";
            5, 6, 7, 8: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [NB-1:0] exp_irq();
        logic [NB-1:0] r;
        for (int b = 0; b < NB; b++) r[b] = m_en[b] & (|m_stat[b*16 +: 16]);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0;
    endtask

    task automatic model_clock(input logic [7:0] a, input logic w, input logic [31:0] d,
                               input logic [NP-1:0] pins);
        logic [NP-1:0] hits, clr;
        int k;
        hits = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
        clr  = '0;
        k    = set_of(a);
        if (w && k >= 0) begin
            case (off_of(a, k))
                0: m_dir[k*32 +: 32] = d;
                2: m_out[k*32 +: 32] = m_out[k*32 +: 32] | d;
                3: m_out[k*32 +: 32] = m_out[k*32 +: 32] & ~d;
                5: m_rise[k*32 +: 32] = m_rise[k*32 +: 32] | d;
                6: m_rise[k*32 +: 32] = m_rise[k*32 +: 32] & ~d;
                7: m_fall[k*32 +: 32] = m_fall[k*32 +: 32] | d;
                8: m_fall[k*32 +: 32] = m_fall[k*32 +: 32] & ~d;
                9: clr[k*32 +: 32] = d;
                default: ;
            endcase
        end
        if (w && a == 8'h08) m_en = d[NB-1:0];
        m_stat = (m_stat & ~clr) | hits;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pins;
    endtask

    // one bus cycle: drive at negedge, check before the edge, advance the model at the edge
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                        input logic [NP-1:0] pins, input string tag = "");
        string t;
        bus_addr = a; bus_we = w; bus_wdata = d; pin_in = pins;
        #1;
        t = (tag == "") ? req_of(a) : tag;
        chk(t, 64'(bus_rdata), 64'(exp_read(a)));
        chk((tag == "") ? "R3" : tag, pin_out, m_out);
        chk((tag == "") ? "R2" : tag, pin_dir, m_dir);
        chk((tag == "") ? "R9" : tag, 64'(bank_irq), 64'(exp_irq()));
        @(posedge clk);
        model_clock(a, w, d, pins);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [NP-1:0] pins;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values over the whole map
        for (int i = 0; i < 24; i++) step(8'(i * 4), 1'b0, '0, '0, "R1");

        // R8 directed: rising edge enable on pin 3, bank 0 enabled
        pins = '0;
        step(8'h24, 1'b1, 32'h8, pins);
        step(8'h08, 1'b1, 32'h1, pins);
        pins[3] = 1'b1;
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b0, '0, pins, "R7");
        // plain clear with no edge
        step(8'h34, 1'b1, 32'h8, pins, "R8");
        step(8'h34, 1'b0, '0, pins, "R8");
        pins[3] = 1'b0;
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b0, '0, pins);
        // new edge lands on the same clock edge as the clear
        pins[3] = 1'b1;
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b0, '0, pins);
        step(8'h34, 1'b1, 32'h8, pins, "R8");
        bus_addr = 8'h34; bus_we = 1'b0; #1;
        chk("R8", 64'(bus_rdata[3]), 64'd1);
        chk("R8", 64'(bank_irq[0]), 64'd1);
        step(8'h34, 1'b0, '0, pins, "R8");

        // R5: output pin still reads the pin level; R4: write to output data ignored
        step(8'h10, 1'b1, 32'hFFFF_FFF0, pins, "R2");
        step(8'h18, 1'b1, 32'h0000_0005, pins, "R3");
        step(8'h14, 1'b1, 32'hFFFF_FFFF, pins, "R4");
        pins[1:0] = 2'b10;
        step(8'h20, 1'b0, '0, pins, "R5");
        step(8'h20, 1'b0, '0, pins, "R5");
        step(8'h20, 1'b0, '0, pins, "R5");
        // R10: unmapped writes
        step(8'h00, 1'b1, 32'hFFFF_FFFF, pins, "R10");
        step(8'h60, 1'b1, 32'hFFFF_FFFF, pins, "R10");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic        w;
            logic [31:0] d;
            if ($urandom_range(0, 9) == 0) a = 8'($urandom_range(24, 63) * 4);
            else                           a = 8'($urandom_range(0, 23) * 4);
            w = ($urandom_range(0, 1) == 1);
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = d & $urandom();
            pins = pins ^ ({$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()});
            step(a, w, d, pins);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule